// File: doc/BRIEF.md
# Watchdog Timer and Clock-Failure Monitor Control

This block combines a periodic-service watchdog with a detector for a slow or stopped bus clock, as found in small microcontrollers. Software reaches it through a narrow register port of three addresses. The first address holds the clock-monitor controls. The second returns the watchdog configuration. The third is where software services the watchdog.

The watchdog enable and its rate field live in working latches. These latches copy a non-volatile configuration byte, which is presented on an input, on the first bus clock after reset is released. They keep that value until the next reset. The watchdog clock is the bus clock divided by 2^PRESCALE_W and then by a further factor chosen by the rate field. If software does not service the watchdog in time, the watchdog raises a reset request.

The clock monitor runs on a free-running reference clock. It watches a toggle driven by the bus clock. If no toggle edge arrives within MON_TIMEOUT reference cycles while the monitor is enabled, it drives a clock-failure reset request for MON_HOLD reference cycles. The monitor is enabled when the software enable bit is set or when the sticky force bit is set. The register port is plain control, with no stream handshake: a write takes effect on the clock edge where `bus_wr` is high, and a read is combinational from `bus_addr`.

Top module: `wdog_clkmon_ctrl`

## Requirements
- R1: Reset clears the monitor enable and force bits, so address 0 reads 0x00. It also deasserts `wdog_rst_req` and `clk_fail_rst`.
- R2: Bit 0 at address 0 is the software monitor enable. Software can write it to 1 or to 0 at any time, and reading address 0 returns the value last written.
- R3: Writing 1 to bit 1 at address 0 sets the force bit. Writing 0 to that bit never clears it; only reset does. While force is set, the monitor is enabled even when bit 0 is 0.
- R4: When force is clear and bit 0 is 0, stopping the bus clock never asserts `clk_fail_rst`.
- R5: When the monitor is enabled and the bus clock stops, `clk_fail_rst` rises no sooner than MON_TIMEOUT and no later than MON_TIMEOUT+SYNC_STAGES+5 reference cycles after the stop. While the bus clock runs, it stays low.
- R6: Each clock-failure request stays high for exactly MON_HOLD consecutive reference cycles.
- R7: On the first bus clock after reset, the latches load from `nv_cfg`: bit 0 is the watchdog enable and bits 2:1 are the rate. Address 1 reads {5'b0, rate, enable}. Later changes to `nv_cfg`, and writes to address 1, have no effect until the next reset.
- R8: With the watchdog enabled and rate r, `wdog_rst_req` rises exactly 4^r * 2^PRESCALE_W bus cycles after the clock edge of the last valid service, or after the latch load. It then stays high until reset.
- R9: A valid service is a write of 0x55 to address 2 followed by a write of 0xAA to address 2, with no other address-2 write between them. A valid service restarts the timeout. A lone 0xAA write, or an 0xAA write after some other value, leaves the timeout running.
- R10: With the latched watchdog enable at 0, `wdog_rst_req` never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the clock being monitored |
| ref_clk | input | 1 | Free-running reference clock for the monitor |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 monitor, 1 config, 2 service) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| nv_cfg | input | 8 | Stored non-volatile configuration byte |
| wdog_rst_req | output | 1 | Watchdog timeout reset request (bus domain, sticky) |
| clk_fail_rst | output | 1 | Clock-failure reset request (reference domain) |

## Verification
The bench builds the block with PRESCALE_W=3, MON_TIMEOUT=12 and MON_HOLD=5. With these values the longest watchdog period, at rate 3, is 512 bus cycles. That brings every rate setting within reach and allows exact cycle counts to each timeout. The short monitor window and hold let the bench gate the bus clock on and off several times. In each case it measures the detection latency and the exact hold length in reference cycles.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_MON = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG = 2'd1;
  localparam logic [ADDR_W-1:0] A_SVC = 2'd2;
  localparam logic [7:0] SVC_ARM  = 8'h55;
  localparam logic [7:0] SVC_FIRE = 8'hAA;
  localparam int RATE_W = 2;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              wd_en;
  } cfg_t;
endpackage

// File: rtl/wdc_regs.sv
module wdc_regs
  import wdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        nv_cfg,
  output logic [7:0]        rdata,
  output logic              mon_sw,
  output logic              mon_force,
  output cfg_t              cfg,
  output logic              cfg_valid,
  output logic              svc_kick
);
  localparam int CFG_W = $bits(cfg_t);

  logic armed;
  logic svc_wr;

  assign svc_wr   = wr_en && (addr == A_SVC);
  assign svc_kick = svc_wr && armed && (wdata == SVC_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_sw    <= 1'b0;
      mon_force <= 1'b0;
      cfg       <= '0;
      cfg_valid <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (!cfg_valid) begin
        cfg       <= cfg_t'(nv_cfg[CFG_W-1:0]);
        cfg_valid <= 1'b1;
      end
      if (wr_en && (addr == A_MON)) begin
        mon_sw <= wdata[0];
        if (wdata[1]) mon_force <= 1'b1;
      end
      if (svc_wr) armed <= (wdata == SVC_ARM);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MON:   rdata = {6'b0, mon_force, mon_sw};
      A_CFG:   rdata = {{(8-CFG_W){1'b0}}, cfg};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdc_wdog.sv
module wdc_wdog
  import wdc_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              kick,
  input  logic [RATE_W-1:0] rate,
  output logic              req
);
  localparam int MULT_W = 2 * ((1 << RATE_W) - 1);

  logic [PRESCALE_W-1:0] pre;
  logic [MULT_W-1:0]     tick_cnt;
  logic [MULT_W-1:0]     lim_m1;

  always_comb begin
    lim_m1 = '0;
    for (int i = 0; i < MULT_W; i++) begin
      lim_m1[i] = (i < 2 * int'(rate));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      tick_cnt <= '0;
      req      <= 1'b0;
    end else if (!en || kick) begin
      pre      <= '0;
      tick_cnt <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (&pre) begin
        if (tick_cnt == lim_m1) req <= 1'b1;
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdc_clkmon.sv
module wdc_clkmon #(
  parameter int MON_TIMEOUT = 16,
  parameter int MON_HOLD    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic bus_tgl,
  input  logic mon_en,
  output logic armed,
  output logic fail
);
  localparam int CNT_W  = $clog2(MON_TIMEOUT + 1);
  localparam int HOLD_W = $clog2(MON_HOLD + 1);
  localparam logic [CNT_W-1:0]  TO_LAST   = CNT_W'(MON_TIMEOUT - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(MON_HOLD - 1);

  logic [SYNC_STAGES-1:0] tsync;
  logic [SYNC_STAGES-1:0] esync;
  logic                   t_last;
  logic                   edge_seen;
  logic [CNT_W-1:0]       silent;
  logic [HOLD_W-1:0]      hold;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tsync  <= '0;
      esync  <= '0;
      t_last <= 1'b0;
    end else begin
      tsync  <= {tsync[SYNC_STAGES-2:0], bus_tgl};
      esync  <= {esync[SYNC_STAGES-2:0], mon_en};
      t_last <= tsync[SYNC_STAGES-1];
    end
  end

  assign edge_seen = tsync[SYNC_STAGES-1] ^ t_last;
  assign armed     = esync[SYNC_STAGES-1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      silent <= '0;
      hold   <= '0;
      fail   <= 1'b0;
    end else if (fail) begin
      silent <= '0;
      if (hold == '0) fail <= 1'b0;
      else            hold <= hold - 1'b1;
    end else if (!armed || edge_seen) begin
      silent <= '0;
    end else if (silent == TO_LAST) begin
      silent <= '0;
      fail   <= 1'b1;
      hold   <= HOLD_LAST;
    end else begin
      silent <= silent + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_clkmon_ctrl.sv
module wdog_clkmon_ctrl
  import wdc_pkg::*;
#(
  parameter int PRESCALE_W  = 15,
  parameter int MON_TIMEOUT = 16,
  parameter int MON_HOLD    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] nv_cfg,
  output logic       wdog_rst_req,
  output logic       clk_fail_rst
);
  logic mon_sw;
  logic mon_force;
  logic eff_en;
  cfg_t cfg_q;
  logic cfg_valid;
  logic svc_kick;
  logic bus_tgl;
  logic mon_armed;

  wdc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .nv_cfg    (nv_cfg),
    .rdata     (bus_rdata),
    .mon_sw    (mon_sw),
    .mon_force (mon_force),
    .cfg       (cfg_q),
    .cfg_valid (cfg_valid),
    .svc_kick  (svc_kick)
  );

  wdc_wdog #(.PRESCALE_W(PRESCALE_W)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg_valid && cfg_q.wd_en),
    .kick  (svc_kick),
    .rate  (cfg_q.rate),
    .req   (wdog_rst_req)
  );

  assign eff_en = mon_sw | mon_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_tgl <= 1'b0;
    else        bus_tgl <= ~bus_tgl;
  end

  wdc_clkmon #(
    .MON_TIMEOUT (MON_TIMEOUT),
    .MON_HOLD    (MON_HOLD),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .bus_tgl (bus_tgl),
    .mon_en  (eff_en),
    .armed   (mon_armed),
    .fail    (clk_fail_rst)
  );
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker #(
  parameter int HOLD_MAX = 8
) (
  input logic       clk,
  input logic       ref_clk,
  input logic       rst_n,
  input logic       mon_force,
  input logic       cfg_valid,
  input logic [2:0] cfg,
  input logic       wd_req,
  input logic       armed,
  input logic       fail
);
  logic [15:0] run_len;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (fail) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mon_force |=> mon_force); // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> (cfg_valid && $stable(cfg))); // R7

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wd_req |=> wd_req); // R8

  AST_WDOG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg[0]) |-> !wd_req); // R10

  AST_NO_FAIL_UNARMED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!armed && !fail) |=> !fail); // R4

  AST_HOLD_BOUND: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail |-> (run_len < 16'(HOLD_MAX))); // R6
endmodule

bind wdog_clkmon_ctrl wdc_checker #(.HOLD_MAX(MON_HOLD)) u_chk (
  .clk       (clk),
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .mon_force (mon_force),
  .cfg_valid (cfg_valid),
  .cfg       (cfg_q),
  .wd_req    (wdog_rst_req),
  .armed     (mon_armed),
  .fail      (clk_fail_rst)
);

// File: tb/wdog_clkmon_ctrl_bench.sv
module wdog_clkmon_ctrl_bench;
  localparam int PW   = 3;
  localparam int TO   = 12;
  localparam int HOLD = 5;
  localparam int SYNC = 2;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, clk_run = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, nv_cfg = '0, bus_rdata;
  logic wdog_rst_req, clk_fail_rst;
  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always begin #4; if (clk_run) clk = ~clk; end
  always #5 ref_clk = ~ref_clk;
  always @(posedge clk) cyc++;

  wdog_clkmon_ctrl #(.PRESCALE_W(PW), .MON_TIMEOUT(TO), .MON_HOLD(HOLD), .SYNC_STAGES(SYNC))
  u_wdog_clkmon_ctrl (.clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nv_cfg(nv_cfg),
    .wdog_rst_req(wdog_rst_req), .clk_fail_rst(clk_fail_rst));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] nv);
    clk_run = 1'b1;
    nv_cfg = nv;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic service(output int t);
    wr(2'd2, 8'h55);
    wr(2'd2, 8'hAA);
    t = cyc;
  endtask

  task automatic wait_req(input int maxc, output int t);
    t = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (wdog_rst_req) begin t = cyc; break; end
    end
  endtask

  task automatic t_reset();
    int v;
    do_reset(8'h00);
    rd(2'd0, v);
    chk(v == 0, "R1 monitor reg", v, 0);
    chk(!wdog_rst_req && !clk_fail_rst, "R1 requests low", int'({wdog_rst_req, clk_fail_rst}), 0);
  endtask

  task automatic t_sw_rw();
    int v;
    do_reset(8'h00);
    wr(2'd0, 8'h01); rd(2'd0, v); chk(v == 1, "R2 set", v, 1);
    wr(2'd0, 8'h00); rd(2'd0, v); chk(v == 0, "R2 clear", v, 0);
    wr(2'd0, 8'h01); rd(2'd0, v); chk(v == 1, "R2 set again", v, 1);
  endtask

  task automatic stop_and_measure(input int maxr, output int n);
    n = -1;
    clk_run = 1'b0;
    for (int i = 1; i <= maxr; i++) begin
      @(negedge ref_clk);
      if (clk_fail_rst) begin n = i; break; end
    end
  endtask

  task automatic t_force();
    int v, n;
    do_reset(8'h00);
    wr(2'd0, 8'h02); rd(2'd0, v); chk(v == 2, "R3 force set", v, 2);
    wr(2'd0, 8'h00); rd(2'd0, v); chk(v == 2, "R3 force kept", v, 2);
    wr(2'd0, 8'h01); rd(2'd0, v); chk(v == 3, "R3 with sw", v, 3);
    wr(2'd0, 8'h00); rd(2'd0, v); chk(v == 2, "R3 sw off", v, 2);
    repeat (8) @(negedge ref_clk);
    stop_and_measure(60, n);
    chk(n > 0, "R3 forced monitor trips", n, TO);
    do_reset(8'h00);
    rd(2'd0, v); chk(v == 0, "R3 reset clears force", v, 0);
  endtask

  task automatic t_mon_off();
    int n;
    do_reset(8'h00);
    wr(2'd0, 8'h01); wr(2'd0, 8'h00);
    repeat (8) @(negedge ref_clk);
    stop_and_measure(50, n);
    chk(n < 0, "R4 no trip while disabled", n, -1);
    clk_run = 1'b1;
  endtask

  task automatic t_mon_fail();
    int n, h, late;
    do_reset(8'h00);
    wr(2'd0, 8'h01);
    late = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge ref_clk);
      if (clk_fail_rst) late++;
    end
    chk(late == 0, "R5 quiet while clock runs", late, 0);
    stop_and_measure(60, n);
    chk(n >= TO && n <= TO + SYNC + 5, "R5 detection latency", n, TO);
    h = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge ref_clk);
      if (!clk_fail_rst) break;
      h++;
    end
    chk(h == HOLD, "R6 hold length", h, HOLD);
    clk_run = 1'b1;
    late = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge ref_clk);
      if (clk_fail_rst) late++;
    end
    chk(late == 0, "R5 no retrip after restart", late, 0);
  endtask

  task automatic t_cfg();
    int v;
    do_reset(8'b1111_1010);
    rd(2'd1, v); chk(v == 2, "R7 load", v, 2);
    nv_cfg = 8'h05;
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk(v == 2, "R7 nv change ignored", v, 2);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk(v == 2, "R7 write ignored", v, 2);
    do_reset(8'h05);
    rd(2'd1, v); chk(v == 5, "R7 reload", v, 5);
  endtask

  task automatic t_rate();
    int t0, t1, exp;
    for (int r = 0; r < 4; r++) begin
      do_reset(8'((r << 1) | 1));
      service(t0);
      exp = (1 << (2 * r)) * (1 << PW);
      wait_req(exp + 50, t1);
      chk(t1 - t0 == exp, "R8 timeout", t1 - t0, exp);
      repeat (5) @(negedge clk);
      chk(wdog_rst_req == 1'b1, "R8 sticky", int'(wdog_rst_req), 1);
    end
  endtask

  task automatic t_svc();
    int t0, t1, exp;
    exp = 4 * (1 << PW);
    do_reset(8'h03);
    service(t0);
    repeat (20) @(negedge clk);
    service(t0);
    wait_req(exp + 50, t1);
    chk(t1 - t0 == exp, "R9 valid service restarts", t1 - t0, exp);
    do_reset(8'h03);
    service(t0);
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
    wr(2'd2, 8'h33);
    wr(2'd2, 8'hAA);
    wait_req(exp + 50, t1);
    chk(t1 - t0 == exp, "R9 bad sequences ignored", t1 - t0, exp);
  endtask

  task automatic t_wd_off();
    int t0;
    do_reset(8'h06);
    service(t0);
    repeat (600) @(negedge clk);
    chk(!wdog_rst_req, "R10 disabled never fires", int'(wdog_rst_req), 0);
  endtask

  initial begin
    t_reset();
    t_sw_rw();
    t_force();
    t_mon_off();
    t_mon_fail();
    t_cfg();
    t_rate();
    t_svc();
    t_wd_off();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule